// File: doc/BRIEF.md
# Power Mode and Slow-Clock Controller

This block sets the operating mode of a small microcontroller core. All clocks are modelled as synchronous enables on one fast clock. A master clock-enable stream comes in. The block turns it into three registered enables: one for the CPU, one for the peripherals and one for the time base. It also reports the current mode and drives two gating flags. One flag stops the CPU clock. The other stops the whole clock tree.

Software writes a configuration word. The word holds a slow-mode enable and a two-bit divide select. When slow mode is on, both the CPU and the peripherals run at the master rate divided by 2, 4, 8 or 16. A wait request parks the CPU while the peripherals keep running, and the current divide setting stays in force. If slow mode is on when the wait starts, the result is a combined slow-wait state. A halt request goes to one of two states, chosen by an oscillator-status input. If the oscillator stays on for the time base, the result is an active-halt state in which only the time-base enable keeps running. Otherwise the result is a full halt. A wake or interrupt event ends a wait or a halt. A new divide setting takes effect only at the next divider terminal count.

Top module: `pmc_top`

## Requirements
- R1: After reset the mode code is 0 (RUN) and both gating flags are low. The CPU and peripheral enables then pulse on every master enable.
- R2: With slow mode on, the peripheral enable period is 2, 4, 8 or 16 master enables. The select value 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. The mode code is 1 (SLOW). With slow mode off, the select value has no effect.
- R3: In SLOW mode the CPU enable and the peripheral enable are identical in every cycle.
- R4: A wait request taken in RUN gives mode code 2 (WAIT). A wait request taken in SLOW gives mode code 3 (SLOW-WAIT). In both states the CPU enable stays low, the CPU gate flag is high, and the peripheral enable keeps its current period.
- R5: A halt request with the oscillator-keep input high gives mode code 4 (ACTIVE-HALT). The CPU and peripheral enables stay low. The time-base enable keeps following the master enable. The CPU gate flag is high and the tree gate flag is low.
- R6: A halt request with the oscillator-keep input low gives mode code 5 (HALT). All three enables stay low and both gating flags are high. When a halt and a wait are requested together, the halt wins.
- R7: A wake event returns WAIT to RUN and SLOW-WAIT to SLOW. The divide period in force before the wait is kept.
- R8: A configuration write takes effect at the next divider terminal count. The enable interval that is running when the write arrives keeps its old length. The interval after it has the new length.
- R9: Reset from any mode, including SLOW-WAIT, returns the block to RUN with slow mode off and the select at 00.
- R10: The divider counts master enables, not clock cycles. An enable pulse follows only a cycle in which the master enable was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Master clock-enable stream |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slow | input | 1 | Slow-mode enable written by cfg_we |
| cfg_sel | input | 2 | Divide select written by cfg_we |
| wait_req | input | 1 | Wait request, one-cycle pulse |
| halt_req | input | 1 | Halt request, one-cycle pulse |
| osc_keep | input | 1 | Oscillator kept running for the time base |
| wake | input | 1 | Wake or interrupt event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| tb_clk_en | output | 1 | Time-base clock enable |
| mode | output | 3 | Current mode code |
| cpu_gate | output | 1 | CPU clock stopped |
| tree_gate | output | 1 | Whole clock tree stopped |

## Verification
The bench measures enable periods for every select value, both at full master rate and with a gapped master stream. A divider that counted raw cycles, or that mapped the select codes in the wrong order, would show the wrong period. It issues a wait in RUN and a wait in SLOW, and then wakes from each. A design that dropped the divider on wait, or that woke from SLOW-WAIT into RUN, would return with the full-rate period or the wrong mode code. It issues a halt with each oscillator status and checks which enables still toggle. It also rewrites the divide ratio in the middle of a period, where a design that applied the change at once would produce a shortened interval.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [2:0] {
    MD_RUN   = 3'd0,
    MD_SLOW  = 3'd1,
    MD_WAIT  = 3'd2,
    MD_SWAIT = 3'd3,
    MD_AHALT = 3'd4,
    MD_HALT  = 3'd5
  } pmc_mode_e;

  typedef enum logic [1:0] {
    ST_ACT   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_AHALT = 2'd2,
    ST_HALT  = 2'd3
  } pmc_state_e;
endpackage

// File: rtl/pmc_slow_div.sv
module pmc_slow_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_en,
  input  logic             cfg_we,
  input  logic             cfg_slow,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             tick,
  output logic             act_slow
);
  localparam int MAX_RATIO = 2 << ((1 << SEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_RATIO);

  logic             pend_slow;
  logic [SEL_W-1:0] pend_sel;
  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    ratio    = (CNT_W+1)'(2) << act_sel;
    last_cnt = CNT_W'(ratio - 1'b1);
    tick     = mclk_en && (!act_slow || (cnt == last_cnt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_slow <= 1'b0;
      pend_sel  <= '0;
      act_slow  <= 1'b0;
      act_sel   <= '0;
      cnt       <= '0;
    end else begin
      if (cfg_we) begin
        pend_slow <= cfg_slow;
        pend_sel  <= cfg_sel;
      end
      if (tick) begin
        act_slow <= pend_slow;
        act_sel  <= pend_sel;
        cnt      <= '0;
      end else if (mclk_en && act_slow) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  cfg_at_tc_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(act_sel) && $stable(act_slow)));
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wait_req,
  input  logic       halt_req,
  input  logic       osc_keep,
  input  logic       wake,
  output pmc_state_e state
);
  pmc_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_ACT: begin
        if (halt_req)      nxt = osc_keep ? ST_AHALT : ST_HALT;
        else if (wait_req) nxt = ST_WAIT;
      end
      ST_WAIT, ST_AHALT, ST_HALT: begin
        if (wake) nxt = ST_ACT;
      end
      default: nxt = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ACT;
    else     state <= nxt;
  end

  // R4
  wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT && wait_req && !halt_req) |=> (state == ST_WAIT));
  // R5
  ahalt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT && halt_req && osc_keep) |=> (state == ST_AHALT));
  // R6
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT && halt_req && !osc_keep) |=> (state == ST_HALT));
  // R7
  wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && wake) |=> (state == ST_ACT));
endmodule

// File: rtl/pmc_clk_out.sv
module pmc_clk_out
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pmc_state_e state,
  input  logic       act_slow,
  input  logic       tick,
  input  logic       mclk_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       tb_clk_en,
  output logic [2:0] mode,
  output logic       cpu_gate,
  output logic       tree_gate
);
  pmc_mode_e md;

  always_comb begin
    case (state)
      ST_ACT:   md = act_slow ? MD_SLOW : MD_RUN;
      ST_WAIT:  md = act_slow ? MD_SWAIT : MD_WAIT;
      ST_AHALT: md = MD_AHALT;
      default:  md = MD_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b0;
      per_clk_en <= 1'b0;
      tb_clk_en  <= 1'b0;
      mode       <= MD_RUN;
      cpu_gate   <= 1'b0;
      tree_gate  <= 1'b0;
    end else begin
      cpu_clk_en <= tick && (state == ST_ACT);
      per_clk_en <= tick && (state == ST_ACT || state == ST_WAIT);
      tb_clk_en  <= mclk_en && (state != ST_HALT);
      mode       <= md;
      cpu_gate   <= (state != ST_ACT);
      tree_gate  <= (state == ST_HALT);
    end
  end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_en,
  input  logic             cfg_we,
  input  logic             cfg_slow,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             wait_req,
  input  logic             halt_req,
  input  logic             osc_keep,
  input  logic             wake,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             tb_clk_en,
  output logic [2:0]       mode,
  output logic             cpu_gate,
  output logic             tree_gate
);
  pmc_state_e state;
  logic       tick;
  logic       act_slow;
  logic       div_mclk;

  assign div_mclk = mclk_en && (state != ST_HALT);

  pmc_slow_div #(.SEL_W(SEL_W)) div_i (
    .clk(clk), .rst(rst), .mclk_en(div_mclk),
    .cfg_we(cfg_we), .cfg_slow(cfg_slow), .cfg_sel(cfg_sel),
    .tick(tick), .act_slow(act_slow)
  );

  pmc_mode_fsm fsm_i (
    .clk(clk), .rst(rst), .wait_req(wait_req), .halt_req(halt_req),
    .osc_keep(osc_keep), .wake(wake), .state(state)
  );

  pmc_clk_out out_i (
    .clk(clk), .rst(rst), .state(state), .act_slow(act_slow),
    .tick(tick), .mclk_en(mclk_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .tb_clk_en(tb_clk_en),
    .mode(mode), .cpu_gate(cpu_gate), .tree_gate(tree_gate)
  );

  // R10
  en_from_master_chk: assert property (@(posedge clk) disable iff (rst)
    per_clk_en |-> $past(mclk_en));
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_HALT) |-> (!cpu_clk_en && !per_clk_en && !tb_clk_en));
  // R3
  slow_match_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SLOW) |-> (cpu_clk_en == per_clk_en));
  // R4
  wait_cpu_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WAIT || mode == MD_SWAIT) |-> !cpu_clk_en);
endmodule

// File: tb/pmc_top_tb_top.sv
module pmc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mclk_en = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_slow = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic       wait_req = 1'b0;
  logic       halt_req = 1'b0;
  logic       osc_keep = 1'b0;
  logic       wake = 1'b0;
  logic       cpu_clk_en, per_clk_en, tb_clk_en, cpu_gate, tree_gate;
  logic [2:0] mode;

  int  n_run = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  half_rate = 1'b0;
  bit  phase = 1'b0;

  always #2.5 clk = ~clk;

  pmc_top dut_i (
    .clk(clk), .rst(rst), .mclk_en(mclk_en), .cfg_we(cfg_we),
    .cfg_slow(cfg_slow), .cfg_sel(cfg_sel), .wait_req(wait_req),
    .halt_req(halt_req), .osc_keep(osc_keep), .wake(wake),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .tb_clk_en(tb_clk_en),
    .mode(mode), .cpu_gate(cpu_gate), .tree_gate(tree_gate)
  );

  always @(negedge clk) begin
    cyc++;
    phase = ~phase;
    mclk_en = half_rate ? phase : 1'b1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wr_cfg(input bit s, input logic [1:0] sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slow = s; cfg_sel = sel;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_pulse();
    int t = 0;
    @(negedge clk);
    while (!per_clk_en && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic measure_gap(output int g);
    wait_pulse();
    g = 0;
    do begin @(negedge clk); g++; end while (!per_clk_en && g < 200);
  endtask

  task automatic count_en(input int n, output int c_cpu, output int c_per, output int c_tb);
    c_cpu = 0; c_per = 0; c_tb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_cpu += int'(cpu_clk_en); c_per += int'(per_clk_en); c_tb += int'(tb_clk_en);
    end
  endtask

  // {slow, sel[1:0], half_rate, expected gap[4:0]}
  localparam logic [8:0] VEC [7] = '{
    {1'b0, 2'b00, 1'b0, 5'd1},
    {1'b1, 2'b00, 1'b0, 5'd2},
    {1'b1, 2'b01, 1'b0, 5'd4},
    {1'b1, 2'b10, 1'b0, 5'd8},
    {1'b1, 2'b11, 1'b0, 5'd16},
    {1'b1, 2'b00, 1'b1, 5'd4},
    {1'b0, 2'b11, 1'b1, 5'd2}
  };

  initial begin
    int g, a, b, c;
    step(3);
    rst = 1'b0;
    step(3);
    // R1 reset state
    chk(mode == 3'd0, "R1 mode", mode, 0);
    chk(!cpu_gate && !tree_gate, "R1 gates", {cpu_gate, tree_gate}, 0);
    count_en(8, a, b, c);
    chk(a == 8 && b == 8, "R1 full-rate enables", a + b, 16);

    // R2 / R10 vector walk
    foreach (VEC[k]) begin
      do_reset();
      half_rate = VEC[k][5];
      wr_cfg(VEC[k][8], VEC[k][7:6]);
      step(40);
      chk(mode == 3'(VEC[k][8]), "R2 mode", mode, int'(VEC[k][8]));
      measure_gap(g);
      chk(g == int'(VEC[k][4:0]), "R2/R10 period", g, int'(VEC[k][4:0]));
    end
    half_rate = 1'b0;

    // R3 slow: cpu equals per
    do_reset(); wr_cfg(1'b1, 2'b01); step(20);
    a = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (cpu_clk_en != per_clk_en) a++;
    end
    chk(a == 0, "R3 cpu/per mismatches", a, 0);

    // R4 slow-wait, then R7 wake back to slow
    do_reset(); wr_cfg(1'b1, 2'b10); step(20);
    pulse(wait_req); step(3);
    chk(mode == 3'd3, "R4 slow-wait mode", mode, 3);
    chk(cpu_gate == 1'b1, "R4 cpu gate", cpu_gate, 1);
    count_en(32, a, b, c);
    chk(a == 0, "R4 cpu enables in slow-wait", a, 0);
    measure_gap(g);
    chk(g == 8, "R4 slow-wait period", g, 8);
    pulse(wake); step(3);
    chk(mode == 3'd1, "R7 wake to slow", mode, 1);
    measure_gap(g);
    chk(g == 8, "R7 period kept", g, 8);

    // R4 plain wait, R7 wake back to run
    do_reset(); step(4);
    pulse(wait_req); step(3);
    chk(mode == 3'd2, "R4 wait mode", mode, 2);
    count_en(16, a, b, c);
    chk(a == 0 && b == 16, "R4 wait enables", a * 100 + b, 16);
    pulse(wake); step(3);
    chk(mode == 3'd0, "R7 wake to run", mode, 0);

    // R5 active-halt
    do_reset(); wr_cfg(1'b1, 2'b00); step(10);
    osc_keep = 1'b1; pulse(halt_req); osc_keep = 1'b0; step(3);
    chk(mode == 3'd4, "R5 active-halt mode", mode, 4);
    chk(cpu_gate && !tree_gate, "R5 gates", {cpu_gate, tree_gate}, 2);
    count_en(32, a, b, c);
    chk(a == 0 && b == 0, "R5 cpu/per stopped", a + b, 0);
    chk(c == 32, "R5 time base running", c, 32);
    pulse(wake); step(3);
    chk(mode == 3'd1, "R5 wake from active-halt", mode, 1);

    // R6 full halt, halt wins over wait
    do_reset(); step(4);
    @(negedge clk); halt_req = 1'b1; wait_req = 1'b1;
    @(negedge clk); halt_req = 1'b0; wait_req = 1'b0;
    step(3);
    chk(mode == 3'd5, "R6 halt mode", mode, 5);
    chk(cpu_gate && tree_gate, "R6 gates", {cpu_gate, tree_gate}, 3);
    count_en(32, a, b, c);
    chk(a + b + c == 0, "R6 all enables stopped", a + b + c, 0);

    // R8 ratio change mid-period: old interval completes, then new
    do_reset(); wr_cfg(1'b1, 2'b11); step(40);
    wait_pulse();
    g = 0;
    do begin
      @(negedge clk); g++;
      if (g == 5) begin cfg_we = 1'b1; cfg_slow = 1'b1; cfg_sel = 2'b00; end
      if (g == 6) cfg_we = 1'b0;
    end while (!per_clk_en && g < 200);
    chk(g == 16, "R8 running interval", g, 16);
    g = 0;
    do begin @(negedge clk); g++; end while (!per_clk_en && g < 200);
    chk(g == 2, "R8 new interval", g, 2);

    // R9 reset out of slow-wait
    do_reset(); wr_cfg(1'b1, 2'b11); step(40);
    pulse(wait_req); step(3);
    do_reset(); step(3);
    chk(mode == 3'd0, "R9 mode after reset", mode, 0);
    measure_gap(g);
    chk(g == 1, "R9 full rate after reset", g, 1);
    wr_cfg(1'b1, 2'b00); step(10);
    measure_gap(g);
    chk(g == 2, "R9 select 00 after reset", g, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule